// File: doc/BRIEF.md
# Master-Mode Serial Audio Port

This block is a serial audio port that owns the link clocks. It divides the system clock down to a bit clock (`sck`) and produces a frame-sync line (`ws`). In each bit period it shifts one bit of a parallel word onto `txd` and captures one bit from `rxd`. Transmit words come in through a valid/ready handshake, one word per channel slot. Received words leave as a one-cycle valid pulse that carries the channel index. The word length, the channels per frame and the divider are parameters.

An 8-bit control word sets the behaviour. It chooses the bit order and the clock edge used to launch data. It sets where frame sync sits (one bit before the first data bit or on it), how long frame sync lasts (one bit or one channel) and its polarity. It also chooses where received bits are captured (mid-bit or end of bit), and it disables transmit and receive separately. The control word is taken in only while `start` is low and is frozen while the port runs. When `start` rises, the port first runs one lead-in bit period that carries no data, so that an early frame sync can come before the first frame. Frames then repeat until `start` falls, and the outputs go back to their idle levels at once.

Top module: `i2s_port`

## Requirements
- R1: While `start` is high, `sck` toggles every DIV system clocks, so one bit period is 2×DIV clocks. While `start` is low, `sck` rests at `cfgIn[1]`, `ws` rests at its inactive level and `txd` is 0. After reset all three are 0.
- R2: `cfgIn[1]` (sckInv) selects the launch edge. At 0, data and frame sync change on the rising `sck` edge and bits are sampled on the falling edge. At 1, both edges are swapped.
- R3: `cfgIn[0]` (lsbFirst) sets the bit order for both directions. At 0, words are sent and assembled from the most significant bit first. At 1, from the least significant bit first.
- R4: `cfgIn[3]` (wsAligned) places frame sync. At 0, `ws` becomes active one bit period before bit 0 of channel 0, including the lead-in period before the first frame. At 1, it becomes active together with that bit.
- R5: `cfgIn[4]` (wsWide) sets the frame-sync width. At 0, `ws` is active for one bit period. At 1, it is active for the whole of channel 0. With one channel per frame, a setting of 1 is treated as 0.
- R6: `cfgIn[2]` (wsLow) sets the frame-sync polarity. At 0, `ws` is active high and idles at 0. At 1, `ws` is active low and idles at 1.
- R7: `cfgIn[5]` (sampleEnd) sets the capture point. At 0, `rxd` is captured at mid-bit, where `sck` makes its sampling transition. At 1, it is captured in the last system clock of the bit. `rxValid` rises in the clock that follows the capture of the final bit.
- R8: `txReady` pulses for one clock before each channel slot, and the word is taken if `txValid` is high in that clock. If `txValid` is low, the slot carries zeros and `txUnderrun` pulses in the same clock.
- R9: Each received word is presented on `rxData` with a one-cycle `rxValid` pulse. `rxChan` counts channels from 0, where channel 0 starts at the frame-sync position.
- R10: `cfgIn[6]` (txOff) set to 1 holds `txd` at 0 and suppresses `txReady` and `txUnderrun`. `cfgIn[7]` (rxOff) set to 1 suppresses `rxValid`.
- R11: The control word is latched only while `start` is low. Changes to `cfgIn` while `start` is high have no effect on the output streams.
- R12: The first launch edge after `start` rises opens a lead-in bit period in which `txd` is 0. Bit 0 of channel 0 follows on the next launch edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Run the port while high; latch `cfgIn` while low |
| cfgIn | input | 8 | Control word (fields listed in R2 to R10) |
| txValid | input | 1 | Transmit word available |
| txData | input | WORD_W | Transmit word |
| txReady | output | 1 | Transmit word taken in this clock |
| txUnderrun | output | 1 | Slot started with no word available |
| rxd | input | 1 | Serial receive data |
| rxValid | output | 1 | Received word valid for one clock |
| rxData | output | WORD_W | Received word |
| rxChan | output | max(1, clog2(CHANS)) | Channel index of the received word |
| sck | output | 1 | Bit clock |
| ws | output | 1 | Frame sync |
| txd | output | 1 | Serial transmit data |

## Verification
`sck`, `ws`, `txd` and `txReady` are decoded from counter registers. Each of them settles in the same clock as the edge that moves the counters. `rxValid`, `rxData` and `rxChan` are registered, so they appear one clock after the edge that captures the last bit. The bench samples every output on the falling system-clock edge. It records `txd` and `ws` just after each launch transition it sees on `sck`, and it checks `rxValid` against the `sck` transition seen in the same sample: the sampling transition for mid-bit capture and the launch transition for end-of-bit capture. Inputs change only on falling edges, or one nanosecond after the rising edge that consumes a transmit word.

// File: rtl/i2sp_pkg.sv
package i2sp_pkg;

  // Control word, bit 0 is lsbFirst.
  typedef struct packed {
    logic rxOff;
    logic txOff;
    logic sampleEnd;
    logic wsWide;
    logic wsAligned;
    logic wsLow;
    logic sckInv;
    logic lsbFirst;
  } cfg_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic run;        // port running
    logic lead;       // lead-in bit period
    logic loadWord;   // slot boundary into bit 0 of a channel
    logic shiftBit;   // slot boundary inside a word
    logic sampleBit;  // capture rxd now
    logic lastBit;    // current bit is the final bit of the word
  } strobe_t;

endpackage

// File: rtl/i2sp_ctrl.sv
module i2sp_ctrl
  import i2sp_pkg::*;
#(
  parameter int DIV    = 4,
  parameter int WORD_W = 16,
  parameter int CHANS  = 2,
  localparam int CH_W  = (CHANS > 1) ? $clog2(CHANS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  cfg_t            cfg,
  output logic            sck,
  output logic            ws,
  output strobe_t         stb,
  output logic [CH_W-1:0] chan
);

  localparam int PH_W  = $clog2(2 * DIV);
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(2 * DIV - 1);
  localparam logic [PH_W-1:0]  PH_MID   = PH_W'(DIV - 1);
  localparam logic [PH_W-1:0]  PH_HALF  = PH_W'(DIV);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);
  localparam logic [CH_W-1:0]  CH_LAST  = CH_W'(CHANS - 1);
  localparam bit WIDE_OK = (CHANS > 1);

  logic             active, lead;
  logic [PH_W-1:0]  ph;
  logic [BIT_W-1:0] bitIdx, nBit;
  logic [CH_W-1:0]  nChan;
  logic             slotEnd, wsAct;

  function automatic logic wsAt(input logic [BIT_W-1:0] b, input logic [CH_W-1:0] c,
                                input logic wide);
    return (c == '0) && ((wide && WIDE_OK) || (b == '0));
  endfunction

  assign slotEnd = active && start && (ph == PH_LAST);
  assign nBit    = (bitIdx == BIT_LAST) ? '0 : bitIdx + 1'b1;
  assign nChan   = (bitIdx != BIT_LAST) ? chan : ((chan == CH_LAST) ? '0 : chan + 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !start) begin
      active <= 1'b0;
      lead   <= 1'b1;
      ph     <= '0;
      bitIdx <= BIT_LAST;
      chan   <= CH_LAST;
    end else begin
      active <= 1'b1;
      if (active) begin
        ph <= slotEnd ? '0 : ph + 1'b1;
        if (slotEnd) begin
          bitIdx <= nBit;
          chan   <= nChan;
          lead   <= 1'b0;
        end
      end
    end
  end

  // Early sync looks one slot ahead; aligned sync uses the current slot.
  always_comb begin
    if (cfg.wsAligned) wsAct = !lead && wsAt(bitIdx, chan, cfg.wsWide);
    else               wsAct = wsAt(nBit, nChan, cfg.wsWide);
  end

  assign sck = active ? ((ph < PH_HALF) ^ cfg.sckInv) : cfg.sckInv;
  assign ws  = active ? (wsAct ^ cfg.wsLow) : cfg.wsLow;

  assign stb.run       = active;
  assign stb.lead      = lead;
  assign stb.loadWord  = slotEnd && (bitIdx == BIT_LAST);
  assign stb.shiftBit  = slotEnd && (bitIdx != BIT_LAST);
  assign stb.sampleBit = active && !lead && (ph == (cfg.sampleEnd ? PH_LAST : PH_MID));
  assign stb.lastBit   = (bitIdx == BIT_LAST);

endmodule

// File: rtl/i2sp_datapath.sv
module i2sp_datapath
  import i2sp_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CH_W   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  cfg_t              cfg,
  input  strobe_t           stb,
  input  logic [CH_W-1:0]   chan,
  input  logic              txValid,
  input  logic [WORD_W-1:0] txData,
  output logic              txReady,
  output logic              txUnderrun,
  output logic              txd,
  input  logic              rxd,
  output logic              rxValid,
  output logic [WORD_W-1:0] rxData,
  output logic [CH_W-1:0]   rxChan
);

  logic [WORD_W-1:0] txShift, rxShift, rxNext;

  assign txReady    = stb.loadWord && !cfg.txOff;
  assign txUnderrun = txReady && !txValid;

  always_ff @(posedge clk) begin
    if (rst || !stb.run)
      txShift <= '0;
    else if (stb.loadWord)
      txShift <= (txValid && !cfg.txOff) ? txData : '0;
    else if (stb.shiftBit)
      txShift <= cfg.lsbFirst ? (txShift >> 1) : (txShift << 1);
  end

  assign txd = stb.run && !stb.lead && !cfg.txOff &&
               (cfg.lsbFirst ? txShift[0] : txShift[WORD_W-1]);

  always_comb begin
    if (cfg.lsbFirst) rxNext = {rxd, rxShift[WORD_W-1:1]};
    else              rxNext = {rxShift[WORD_W-2:0], rxd};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxShift <= '0;
      rxValid <= 1'b0;
      rxData  <= '0;
      rxChan  <= '0;
    end else begin
      rxValid <= 1'b0;
      if (stb.sampleBit && !cfg.rxOff) begin
        rxShift <= rxNext;
        if (stb.lastBit) begin
          rxValid <= 1'b1;
          rxData  <= rxNext;
          rxChan  <= chan;
        end
      end
    end
  end

endmodule

// File: rtl/i2s_port.sv
module i2s_port
  import i2sp_pkg::*;
#(
  parameter int DIV    = 4,
  parameter int WORD_W = 16,
  parameter int CHANS  = 2,
  localparam int CH_W  = (CHANS > 1) ? $clog2(CHANS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        cfgIn,
  input  logic              txValid,
  input  logic [WORD_W-1:0] txData,
  output logic              txReady,
  output logic              txUnderrun,
  input  logic              rxd,
  output logic              rxValid,
  output logic [WORD_W-1:0] rxData,
  output logic [CH_W-1:0]   rxChan,
  output logic              sck,
  output logic              ws,
  output logic              txd
);

  cfg_t            cfgQ;
  strobe_t         stb;
  logic [CH_W-1:0] chan;

  // Settings are taken only while the port is stopped.
  always_ff @(posedge clk) begin
    if (rst)         cfgQ <= '0;
    else if (!start) cfgQ <= cfg_t'(cfgIn);
  end

  i2sp_ctrl #(.DIV(DIV), .WORD_W(WORD_W), .CHANS(CHANS)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .cfg(cfgQ),
    .sck(sck), .ws(ws), .stb(stb), .chan(chan)
  );

  i2sp_datapath #(.WORD_W(WORD_W), .CH_W(CH_W)) u_dp (
    .clk(clk), .rst(rst), .cfg(cfgQ), .stb(stb), .chan(chan),
    .txValid(txValid), .txData(txData), .txReady(txReady), .txUnderrun(txUnderrun),
    .txd(txd), .rxd(rxd), .rxValid(rxValid), .rxData(rxData), .rxChan(rxChan)
  );

endmodule

// File: rtl/i2s_port_chk.sv
module i2s_port_chk
  import i2sp_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic start,
  input cfg_t cfgQ,
  input logic sck,
  input logic ws,
  input logic txd,
  input logic txValid,
  input logic txReady,
  input logic txUnderrun,
  input logic rxValid
);

  assert_idle_levels_R1: assert property (@(posedge clk) disable iff (rst)
    !start |=> (sck == cfgQ.sckInv && ws == cfgQ.wsLow && !txd));

  assert_ws_on_launch_R2: assert property (@(posedge clk) disable iff (rst)
    (start && $past(start) && !$stable(ws)) |->
      (sck != cfgQ.sckInv && $past(sck) == cfgQ.sckInv));

  assert_underrun_R8: assert property (@(posedge clk) disable iff (rst)
    txUnderrun |-> (txReady && !txValid));

  assert_tx_off_R10: assert property (@(posedge clk) disable iff (rst)
    cfgQ.txOff |-> (!txReady && !txd));

  assert_rx_off_R10: assert property (@(posedge clk) disable iff (rst)
    (cfgQ.rxOff && $past(cfgQ.rxOff)) |-> !rxValid);

  assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (rst)
    (start && $past(start)) |-> $stable(cfgQ));

endmodule

bind i2s_port i2s_port_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .cfgQ(cfgQ), .sck(sck), .ws(ws), .txd(txd),
  .txValid(txValid), .txReady(txReady), .txUnderrun(txUnderrun), .rxValid(rxValid)
);

// File: tb/i2s_port_tb.sv
`timescale 1ns/1ps
module i2s_port_tb;
  import i2sp_pkg::*;

  localparam int DIV = 2, W = 8, CH = 2, FRAME = W * CH;
  localparam int MW = 4;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [7:0] cfgIn = 8'h00;
  logic txValid = 1'b0;
  logic [W-1:0] txData = '0;
  logic txReady, txUnderrun, rxValid, sck, ws, txd, rxd;
  logic [W-1:0] rxData;
  logic [0:0] rxChan;
  logic mReady, mUnder, mRxValid, mSck, mWs, mTxd;
  logic [MW-1:0] mRxData;
  logic [0:0] mRxChan;

  always #2 clk = ~clk;
  assign rxd = txd;  // loopback

  i2s_port #(.DIV(DIV), .WORD_W(W), .CHANS(CH)) u_dut (
    .clk(clk), .rst(rst), .start(start), .cfgIn(cfgIn), .txValid(txValid), .txData(txData),
    .txReady(txReady), .txUnderrun(txUnderrun), .rxd(rxd), .rxValid(rxValid),
    .rxData(rxData), .rxChan(rxChan), .sck(sck), .ws(ws), .txd(txd));

  i2s_port #(.DIV(DIV), .WORD_W(MW), .CHANS(1)) u_dut_mono (
    .clk(clk), .rst(rst), .start(start), .cfgIn(cfgIn), .txValid(1'b0), .txData('0),
    .txReady(mReady), .txUnderrun(mUnder), .rxd(1'b0), .rxValid(mRxValid),
    .rxData(mRxData), .rxChan(mRxChan), .sck(mSck), .ws(mWs), .txd(mTxd));

  int checks = 0, errors = 0, cyc = 0, lastL = 0;
  int urCnt, rdyCnt, monoRun, monoMax;
  bit feedOn = 0, launch, done = 0;
  logic prevSck = 1'b0;
  cfg_t curCfg = '0;
  logic [W-1:0] sentQ[$], rxQ[$];
  int rxChQ[$];
  bit slotWs[$], slotTx[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic bit wsAt(int b, int c, bit wide);
    return (c == 0) && (wide || b == 0);
  endfunction

  function automatic bit expWs(int s, cfg_t c);
    bit wide = c.wsWide && (CH > 1);
    bit cur = 0;
    int np = 0;
    if (s > 0) begin
      int p = (s - 1) % FRAME;
      cur = wsAt(p % W, p / W, wide);
      np = (p + 1) % FRAME;
    end
    return (c.wsAligned ? cur : wsAt(np % W, np / W, wide)) ^ c.wsLow;
  endfunction

  function automatic bit expTx(int s, cfg_t c, bit feed);
    int b;
    logic [W-1:0] wd;
    if (s == 0 || c.txOff || !feed) return 0;
    if ((s - 1) / W >= sentQ.size()) return 1'bx;
    wd = sentQ[(s - 1) / W];
    b = (s - 1) % W;
    return c.lsbFirst ? wd[b] : wd[W-1-b];
  endfunction

  // transmit word source
  always begin
    @(negedge clk);
    txValid = feedOn;
    if (txReady) begin
      if (txValid) sentQ.push_back(txData);
      @(posedge clk);
      #1 txData = W'($urandom());
    end
  end

  // monitor
  always @(negedge clk) begin
    cyc++;
    if (start && !rst) begin
      launch = (prevSck == curCfg.sckInv) && (sck != curCfg.sckInv);
      if (launch) begin
        if (slotWs.size() > 0) chk(cyc - lastL == 2 * DIV, "R1 sck period", cyc - lastL, 2 * DIV);
        lastL = cyc;
        slotWs.push_back(ws);
        slotTx.push_back(txd);
      end
      if (rxValid) begin
        rxQ.push_back(rxData);
        rxChQ.push_back(int'(rxChan));
        chk(curCfg.sampleEnd ? launch : (prevSck != curCfg.sckInv && sck == curCfg.sckInv),
            "R7 capture point", int'(sck), int'(curCfg.sampleEnd));
      end
      if (txUnderrun) urCnt++;
      if (txReady) rdyCnt++;
      if (mWs != curCfg.wsLow) begin
        monoRun++;
        if (monoRun > monoMax) monoMax = monoRun;
      end else monoRun = 0;
    end
    prevSck = sck;
  end

  task automatic runCase(input cfg_t c, input int frames, input bit feed, input bit disturb);
    int nSlots = 1 + frames * FRAME;
    int nWords = frames * CH;
    @(negedge clk);
    cfgIn = c; curCfg = c; feedOn = feed; start = 0;
    repeat (3) @(negedge clk);
    sentQ.delete(); rxQ.delete(); rxChQ.delete(); slotWs.delete(); slotTx.delete();
    urCnt = 0; rdyCnt = 0; monoRun = 0; monoMax = 0;
    start = 1;
    for (int i = 0; i < (nSlots + 1) * 2 * DIV; i++) begin
      @(negedge clk);
      if (disturb && i == 20) cfgIn = c ^ 8'h1B;  // R11: ignored while running
      if (disturb && i == 60) cfgIn = c ^ 8'h24;
    end
    cfgIn = c; start = 0; feedOn = 0;
    repeat (3) @(negedge clk);
    chk(sck == c.sckInv, "R1 idle sck", sck, c.sckInv);
    chk(ws == c.wsLow, "R6 idle ws", ws, c.wsLow);
    chk(txd == 1'b0, "R1 idle txd", txd, 0);
    chk(slotWs.size() >= nSlots, "R12 slot count", slotWs.size(), nSlots);
    for (int s = 0; s < nSlots && s < slotWs.size(); s++) begin
      bit ew = expWs(s, c);
      logic et = expTx(s, c, feed);
      if (slotWs[s] != ew) chk(0, "R4/R5/R6 ws slot", s, ew);
      else checks++;
      if (s == 0) chk(slotTx[s] == 0, "R12 lead-in txd", slotTx[s], 0);
      else if (slotTx[s] !== et) chk(0, "R3 txd bit", s, et);
      else checks++;
    end
    chk(monoMax == 2 * DIV, "R5 single-channel pulse", monoMax, 2 * DIV);
    if (c.txOff) begin
      chk(rdyCnt == 0 && urCnt == 0, "R10 tx off", rdyCnt + urCnt, 0);
    end else if (!feed) begin
      chk(urCnt >= nWords && sentQ.size() == 0, "R8 underrun", urCnt, nWords);
    end else begin
      chk(urCnt == 0 && sentQ.size() >= nWords, "R8 handshake", sentQ.size(), nWords);
    end
    if (c.rxOff) chk(rxQ.size() == 0, "R10 rx off", rxQ.size(), 0);
    else begin
      chk(rxQ.size() >= nWords, "R9 rx count", rxQ.size(), nWords);
      for (int k = 0; k < nWords && k < rxQ.size(); k++) begin
        logic [W-1:0] ex = (feed && !c.txOff && k < sentQ.size()) ? sentQ[k] : '0;
        chk(rxQ[k] == ex, "R9 rx word", rxQ[k], ex);
        chk(rxChQ[k] == k % CH, "R9 rx channel", rxChQ[k], k % CH);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'd4242));
    txData = W'($urandom());
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(sck == 0 && ws == 0 && txd == 0, "R1 reset outputs", {sck, ws, txd}, 0);
    chk(txReady == 0 && rxValid == 0, "R1 reset strobes", {txReady, rxValid}, 0);
    runCase(cfg_t'(8'h00), 3, 1, 0);  // msb first, early one-bit sync
    runCase(cfg_t'(8'h01), 3, 1, 0);  // R3 lsb first
    runCase(cfg_t'(8'h1A), 3, 1, 0);  // R2 R4 R5 R6 aligned wide, inverted
    runCase(cfg_t'(8'h30), 3, 1, 0);  // R7 end sampling, wide early
    runCase(cfg_t'(8'h00), 2, 0, 0);  // R8 underrun
    runCase(cfg_t'(8'h40), 2, 1, 0);  // R10 tx off
    runCase(cfg_t'(8'h80), 2, 1, 0);  // R10 rx off
    runCase(cfg_t'(8'h14), 3, 1, 1);  // R11 changes while running
    for (int i = 0; i < 6; i++) runCase(cfg_t'(8'($urandom()) & 8'h3F), 2, 1, (i % 2) == 1);
    finishRun();
  end

endmodule